// File: doc/BRIEF.md
# Target Read Prefetch FIFO

This block carries prefetched read data from an application clock domain to a PCI clock domain. On the application side, narrow beats are packed into full FIFO words. Each beat is captured on a rising edge of the application clock while the active-low write enable is low. The application watches the active-low full flag for back-pressure. It also watches an almost-full flag, which warns it four entries ahead. A word completed while the FIFO is full is discarded and reported. An address generator runs alongside the writes. It gives the double-word address of the word being prefetched and tells the application when to stop: either on an end-of-transfer marker or at the top of the target's decode window.

The PCI side drains words through a valid/ready handshake. A word moves on a rising PCI clock edge when `rd_valid` and `rd_ready` are both high. While `rd_valid` is high and `rd_ready` is low, the word on offer and its data stay unchanged. A hold input lets the application delay the start of a burst so that the FIFO can fill first. The burst begins when hold drops or when the FIFO is seen as full. Once a burst has begun, it runs until the FIFO is empty. Pointers cross between the two clock domains in Gray code through two-flop synchronizers.

Top module: `tgt_rd_fifo`

## Requirements
- R1: A beat is captured on a rising `aclk` edge while `wr_en_n` is low. `CYC_PER_WORD` beats (default 2 beats of 16 bits) make one FIFO word, and the first beat fills the least significant bits.
- R2: Words leave on `rd_data` in the order they were written, one per `pclk` edge with `rd_valid` and `rd_ready` both high. While `rd_valid` is high and `rd_ready` is low, `rd_valid` stays high and `rd_data` holds.
- R3: `full_n` is low while all `DEPTH` (default 16) entries are occupied. A word completed while `full_n` is low is not stored, and `wr_ovf` pulses high for one `aclk` cycle.
- R4: `afull_n` is low whenever four or fewer entries are free. With 11 words stored it is high; with 12 it is low.
- R5: `empty_n` is synchronous to `pclk` and is low when no stored word is visible to the PCI side. `rd_valid` is never high while `empty_n` is low.
- R6: While `hold` is high, no burst is in progress and the FIFO is not full, `rd_valid` stays low even when words are stored.
- R7: When the PCI side sees the FIFO full, `rd_valid` rises even though `hold` is high. Once a burst has begun, it keeps offering words until the FIFO is empty, whatever `hold` does.
- R8: Once `hold` rises, it must stay high for at least two `pclk` periods.
- R9: A `pf_start` pulse with a double-word-aligned address inside [`RANGE_LO`, `RANGE_HI`] loads `pf_addr` and raises `pf_active`. An address outside the window clears `pf_active`. Each word stored while `pf_active` is high advances `pf_addr` by 4.
- R10: `wr_last_n` low on the final beat of a stored word ends prefetch. `pf_active` drops and `pf_addr` keeps that word's address. `wr_last_n` low on any earlier beat has no effect.
- R11: Storing a word at address `RANGE_HI` ends prefetch, and `pf_addr` stays at `RANGE_HI`.
- R12: After reset: `full_n` and `afull_n` are high; `empty_n`, `rd_valid`, `pf_active` and `wr_ovf` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aclk | input | 1 | Application clock |
| arst_n | input | 1 | Asynchronous active-low reset, application domain |
| wr_en_n | input | 1 | Active-low beat write enable |
| wr_data | input | IN_W | Beat data |
| wr_last_n | input | 1 | Active-low end marker, sampled on the final beat of a word |
| pf_start | input | 1 | Loads the prefetch start address |
| pf_start_addr | input | ADDR_W | Prefetch start byte address |
| pf_active | output | 1 | Prefetch still in progress |
| pf_addr | output | ADDR_W | Address of the word being prefetched |
| full_n | output | 1 | Active-low FIFO full |
| afull_n | output | 1 | Active-low almost full (four or fewer free) |
| wr_ovf | output | 1 | One-cycle pulse: a word was dropped because the FIFO was full |
| pclk | input | 1 | PCI-side clock |
| prst_n | input | 1 | Asynchronous active-low reset, PCI domain |
| hold | input | 1 | Delays the start of a burst |
| rd_valid | output | 1 | A word is offered on `rd_data` |
| rd_ready | input | 1 | PCI side accepts the offered word |
| rd_data | output | DATA_W | Offered word |
| empty_n | output | 1 | Active-low FIFO empty, PCI domain |

## Verification
A wrong write pointer or wrong beat packing shows up as a scoreboard mismatch on `rd_data`. That appears as soon as the affected word is drained, a few PCI cycles after the synchronizers settle. A wrong occupancy count shows up at once in `afull_n` or `full_n`, on the `aclk` edge that stores the 12th or 16th word. On the PCI side it shows up as `rd_valid` rising under hold or never rising, within about three `pclk` cycles. A wrong address generator shows up in `pf_addr` and `pf_active` right after the edge that stores the word concerned.

// File: rtl/trf_pkg.sv
package trf_pkg;
  // bytes covered by one prefetch step
  localparam int DWORD_BYTES = 4;
  // free-slot count at which the almost-full warning asserts
  localparam int FREE_MARK_DEF = 4;
endpackage

// File: rtl/trf_ptr_sync.sv
module trf_ptr_sync #(
  parameter int W = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= gray_in;
      sync_q <= meta_q;
    end
  end

  // Gray to binary: bit i is the parity of bits i and above
  for (genvar i = 0; i < W; i++) begin : g_dec
    assign bin_out[i] = ^(sync_q >> i);
  end
endmodule

// File: rtl/trf_ram.sv
module trf_ram #(
  parameter int DEPTH = 16,
  parameter int W     = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/trf_wside.sv
module trf_wside #(
  parameter int DEPTH     = 16,
  parameter int FREE_MARK = 4,
  localparam int AW       = $clog2(DEPTH),
  localparam int PW       = AW + 1
) (
  input  logic          aclk,
  input  logic          arst_n,
  input  logic          push,
  input  logic [PW-1:0] rbin_s,
  output logic          wen,
  output logic [AW-1:0] waddr,
  output logic [PW-1:0] wgray,
  output logic          full,
  output logic          afull,
  output logic          ovf
);
  localparam logic [PW-1:0] CAP  = PW'(DEPTH);
  localparam logic [PW-1:0] MARK = PW'(DEPTH - FREE_MARK);

  logic [PW-1:0] wbin, wbin_nx, used;

  assign used    = wbin - rbin_s;
  assign full    = (used == CAP);
  assign afull   = (used >= MARK);
  assign wen     = push & ~full;
  assign wbin_nx = wbin + PW'(1);
  assign waddr   = wbin[AW-1:0];

  always_ff @(posedge aclk or negedge arst_n) begin
    if (!arst_n) begin
      wbin  <= '0;
      wgray <= '0;
      ovf   <= 1'b0;
    end else begin
      ovf <= push & full;
      if (wen) begin
        wbin  <= wbin_nx;
        wgray <= wbin_nx ^ (wbin_nx >> 1);
      end
    end
  end
endmodule

// File: rtl/trf_rside.sv
module trf_rside #(
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH),
  localparam int PW   = AW + 1
) (
  input  logic          pclk,
  input  logic          prst_n,
  input  logic [PW-1:0] wbin_s,
  input  logic          hold,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [AW-1:0] raddr,
  output logic [PW-1:0] rgray,
  output logic          empty
);
  localparam logic [PW-1:0] CAP = PW'(DEPTH);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] rbin, rbin_nx, used;
  logic          burst_on, seen_full, go, pop;

  assign used      = wbin_s - rbin;
  assign empty     = (used == '0);
  assign seen_full = (used == CAP);
  // start when hold drops or the FIFO has filled; a started burst runs on
  assign go        = burst_on | ~hold | seen_full;
  assign rd_valid  = ~empty & go;
  assign pop       = rd_valid & rd_ready;
  assign rbin_nx   = rbin + ONE;
  assign raddr     = rbin[AW-1:0];

  always_ff @(posedge pclk or negedge prst_n) begin
    if (!prst_n) begin
      rbin     <= '0;
      rgray    <= '0;
      burst_on <= 1'b0;
    end else begin
      if (pop) begin
        rbin  <= rbin_nx;
        rgray <= rbin_nx ^ (rbin_nx >> 1);
      end
      if (pop && used == ONE) burst_on <= 1'b0;
      else if (rd_valid)      burst_on <= 1'b1;
    end
  end
endmodule

// File: rtl/trf_prefetch.sv
module trf_prefetch
  import trf_pkg::*;
#(
  parameter int              IN_W         = 16,
  parameter int              CYC_PER_WORD = 2,
  parameter int              ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] RANGE_LO   = 'h100,
  parameter logic [ADDR_W-1:0] RANGE_HI   = 'h1FC,
  localparam int             DATA_W       = IN_W * CYC_PER_WORD,
  localparam int             CW           = (CYC_PER_WORD > 1) ? $clog2(CYC_PER_WORD) : 1
) (
  input  logic              aclk,
  input  logic              arst_n,
  input  logic              wr_en_n,
  input  logic [IN_W-1:0]   wr_data,
  input  logic              wr_last_n,
  input  logic              pf_start,
  input  logic [ADDR_W-1:0] pf_start_addr,
  input  logic              full,
  output logic              push,
  output logic [DATA_W-1:0] push_data,
  output logic              pf_active,
  output logic [ADDR_W-1:0] pf_addr
);
  localparam logic [CW-1:0]     LAST_BEAT = CW'(CYC_PER_WORD - 1);
  localparam logic [ADDR_W-1:0] STEP      = ADDR_W'(DWORD_BYTES);

  logic          beat, final_beat, stored, start_ok;
  logic [CW-1:0] bcnt;

  assign beat       = ~wr_en_n;
  assign final_beat = beat & (bcnt == LAST_BEAT);
  assign push       = final_beat;
  assign stored     = final_beat & ~full;
  assign start_ok   = (pf_start_addr >= RANGE_LO) && (pf_start_addr <= RANGE_HI)
                      && (pf_start_addr[1:0] == 2'b00);

  always_ff @(posedge aclk or negedge arst_n) begin
    if (!arst_n) begin
      bcnt <= '0;
    end else if (beat) begin
      bcnt <= final_beat ? '0 : bcnt + CW'(1);
    end
  end

  if (CYC_PER_WORD == 1) begin : g_single
    assign push_data = wr_data;
  end else begin : g_pack
    localparam int ACC_W = DATA_W - IN_W;
    logic [ACC_W-1:0] acc;
    always_ff @(posedge aclk or negedge arst_n) begin
      if (!arst_n) begin
        acc <= '0;
      end else if (beat && !final_beat) begin
        acc[bcnt*IN_W +: IN_W] <= wr_data;
      end
    end
    assign push_data = {wr_data, acc};
  end

  always_ff @(posedge aclk or negedge arst_n) begin
    if (!arst_n) begin
      pf_active <= 1'b0;
      pf_addr   <= '0;
    end else if (pf_start) begin
      pf_active <= start_ok;
      if (start_ok) pf_addr <= pf_start_addr;
    end else if (stored && pf_active) begin
      if (!wr_last_n || pf_addr == RANGE_HI) pf_active <= 1'b0;
      else                                   pf_addr   <= pf_addr + STEP;
    end
  end
endmodule

// File: rtl/tgt_rd_fifo.sv
module tgt_rd_fifo
  import trf_pkg::*;
#(
  parameter int                DEPTH        = 16,
  parameter int                IN_W         = 16,
  parameter int                CYC_PER_WORD = 2,
  parameter int                ADDR_W       = 32,
  parameter logic [ADDR_W-1:0] RANGE_LO     = 'h100,
  parameter logic [ADDR_W-1:0] RANGE_HI     = 'h1FC,
  localparam int               DATA_W       = IN_W * CYC_PER_WORD,
  localparam int               AW           = $clog2(DEPTH),
  localparam int               PW           = AW + 1
) (
  input  logic              aclk,
  input  logic              arst_n,
  input  logic              wr_en_n,
  input  logic [IN_W-1:0]   wr_data,
  input  logic              wr_last_n,
  input  logic              pf_start,
  input  logic [ADDR_W-1:0] pf_start_addr,
  output logic              pf_active,
  output logic [ADDR_W-1:0] pf_addr,
  output logic              full_n,
  output logic              afull_n,
  output logic              wr_ovf,
  input  logic              pclk,
  input  logic              prst_n,
  input  logic              hold,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [DATA_W-1:0] rd_data,
  output logic              empty_n
);
  logic              push, wen, full, afull, empty;
  logic [DATA_W-1:0] push_data;
  logic [AW-1:0]     waddr, raddr;
  logic [PW-1:0]     wgray, rgray, wbin_s, rbin_s;

  trf_prefetch #(
    .IN_W(IN_W), .CYC_PER_WORD(CYC_PER_WORD), .ADDR_W(ADDR_W),
    .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
  ) u_pf (
    .aclk(aclk), .arst_n(arst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .wr_last_n(wr_last_n), .pf_start(pf_start), .pf_start_addr(pf_start_addr),
    .full(full), .push(push), .push_data(push_data),
    .pf_active(pf_active), .pf_addr(pf_addr)
  );

  trf_wside #(.DEPTH(DEPTH), .FREE_MARK(FREE_MARK_DEF)) u_ws (
    .aclk(aclk), .arst_n(arst_n), .push(push), .rbin_s(rbin_s),
    .wen(wen), .waddr(waddr), .wgray(wgray), .full(full), .afull(afull), .ovf(wr_ovf)
  );

  trf_ptr_sync #(.W(PW)) u_r2a (
    .clk(aclk), .rst_n(arst_n), .gray_in(rgray), .bin_out(rbin_s)
  );

  trf_ptr_sync #(.W(PW)) u_w2p (
    .clk(pclk), .rst_n(prst_n), .gray_in(wgray), .bin_out(wbin_s)
  );

  trf_ram #(.DEPTH(DEPTH), .W(DATA_W)) u_ram (
    .clk(aclk), .we(wen), .waddr(waddr), .wdata(push_data),
    .raddr(raddr), .rdata(rd_data)
  );

  trf_rside #(.DEPTH(DEPTH)) u_rs (
    .pclk(pclk), .prst_n(prst_n), .wbin_s(wbin_s), .hold(hold),
    .rd_ready(rd_ready), .rd_valid(rd_valid), .raddr(raddr), .rgray(rgray), .empty(empty)
  );

  assign full_n  = ~full;
  assign afull_n = ~afull;
  assign empty_n = ~empty;
endmodule

// File: rtl/trf_checks.sv
module trf_checks #(
  parameter int                DATA_W   = 32,
  parameter int                ADDR_W   = 32,
  parameter logic [ADDR_W-1:0] RANGE_LO = 'h100,
  parameter logic [ADDR_W-1:0] RANGE_HI = 'h1FC
) (
  input logic              aclk,
  input logic              arst_n,
  input logic              pclk,
  input logic              prst_n,
  input logic              full_n,
  input logic              afull_n,
  input logic              wr_ovf,
  input logic              pf_start,
  input logic              pf_active,
  input logic [ADDR_W-1:0] pf_addr,
  input logic              hold,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [DATA_W-1:0] rd_data,
  input logic              empty_n
);
  // R2: an offered word is held until taken
  p_hold_offer_r2: assert property (@(posedge pclk) disable iff (!prst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

  // R3: a drop report only follows a full FIFO
  p_no_overflow_r3: assert property (@(posedge aclk) disable iff (!arst_n)
    wr_ovf |-> $past(!full_n));

  // R4: full implies almost full
  p_afull_cover_r4: assert property (@(posedge aclk) disable iff (!arst_n)
    !full_n |-> !afull_n);

  // R5: nothing offered while empty
  p_no_offer_empty_r5: assert property (@(posedge pclk) disable iff (!prst_n)
    !empty_n |-> !rd_valid);

  // R8: hold lasts at least two PCI clocks
  p_hold_min_r8: assert property (@(posedge pclk) disable iff (!prst_n)
    $rose(hold) |=> hold);

  // R9: address only moves in double-word steps while active
  p_addr_step_r9: assert property (@(posedge aclk) disable iff (!arst_n)
    (pf_active && $past(pf_active) && !$past(pf_start) && !$stable(pf_addr))
      |-> (pf_addr == $past(pf_addr) + ADDR_W'(4)));

  // R11: an active prefetch stays inside the decode window
  p_in_window_r11: assert property (@(posedge aclk) disable iff (!arst_n)
    pf_active |-> (pf_addr >= RANGE_LO && pf_addr <= RANGE_HI));
endmodule

bind tgt_rd_fifo trf_checks #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .RANGE_LO(RANGE_LO), .RANGE_HI(RANGE_HI)
) u_chk (
  .aclk(aclk), .arst_n(arst_n), .pclk(pclk), .prst_n(prst_n),
  .full_n(full_n), .afull_n(afull_n), .wr_ovf(wr_ovf), .pf_start(pf_start),
  .pf_active(pf_active), .pf_addr(pf_addr), .hold(hold), .rd_valid(rd_valid),
  .rd_ready(rd_ready), .rd_data(rd_data), .empty_n(empty_n)
);

// File: tb/tgt_rd_fifo_test.sv
module tgt_rd_fifo_test;
  logic        aclk = 1'b0, pclk = 1'b0, arst_n = 1'b0, prst_n = 1'b0;
  logic        wr_en_n = 1'b1, wr_last_n = 1'b1, pf_start = 1'b0;
  logic [15:0] wr_data = '0;
  logic [31:0] pf_start_addr = '0;
  logic        hold = 1'b0, rd_ready = 1'b0;
  logic        pf_active, full_n, afull_n, wr_ovf, rd_valid, empty_n;
  logic [31:0] pf_addr, rd_data;

  int errors = 0, checks = 0, ovf_cnt = 0, pops = 0;
  bit finished = 1'b0;
  logic [31:0] exp_q[$];

  always #4 aclk = ~aclk;   // 125 MHz application clock
  always #6 pclk = ~pclk;   // PCI-side clock

  tgt_rd_fifo uut (
    .aclk(aclk), .arst_n(arst_n), .wr_en_n(wr_en_n), .wr_data(wr_data),
    .wr_last_n(wr_last_n), .pf_start(pf_start), .pf_start_addr(pf_start_addr),
    .pf_active(pf_active), .pf_addr(pf_addr), .full_n(full_n), .afull_n(afull_n),
    .wr_ovf(wr_ovf), .pclk(pclk), .prst_n(prst_n), .hold(hold),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data), .empty_n(empty_n)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // driver: two beats per word, low half first (R1)
  task automatic put_word(input logic [31:0] d, input logic lastf, input logic lasti, input bit store);
    @(posedge aclk); #1;
    wr_en_n = 1'b0; wr_data = d[15:0]; wr_last_n = lasti;
    @(posedge aclk); #1;
    wr_data = d[31:16]; wr_last_n = lastf;
    @(posedge aclk); #1;
    wr_en_n = 1'b1; wr_last_n = 1'b1;
    if (store) exp_q.push_back(d);
  endtask

  task automatic start_pf(input logic [31:0] a);
    @(posedge aclk); #1; pf_start = 1'b1; pf_start_addr = a;
    @(posedge aclk); #1; pf_start = 1'b0;
  endtask

  task automatic set_pci(input logic h, input logic r);
    @(posedge pclk); #2; hold = h; rd_ready = r;
  endtask

  task automatic wait_drain(input string req);
    for (int i = 0; i < 600 && exp_q.size() != 0; i++) @(posedge pclk);
    repeat (6) @(posedge pclk);
    #3;
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    check(empty_n == 1'b0, "R5 empty after drain", empty_n, 0);
  endtask

  // monitor: compares each accepted word with the scoreboard head (R1, R2)
  always @(negedge pclk) begin
    if (prst_n && rd_valid && rd_ready) begin
      pops++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R2 unexpected word", rd_data, 0);
      end else begin
        check(rd_data == exp_q[0], "R1/R2 order and packing", rd_data, exp_q[0]);
        void'(exp_q.pop_front());
      end
    end
  end

  always @(negedge aclk) if (arst_n && wr_ovf) ovf_cnt++;

  initial begin
    #2_000_000;
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(posedge pclk);
    #1; arst_n = 1'b1; prst_n = 1'b1;
    @(posedge aclk); #3;
    // R12 reset state
    check(full_n == 1'b1,    "R12 full_n",    full_n, 1);
    check(afull_n == 1'b1,   "R12 afull_n",   afull_n, 1);
    check(empty_n == 1'b0,   "R12 empty_n",   empty_n, 0);
    check(rd_valid == 1'b0,  "R12 rd_valid",  rd_valid, 0);
    check(pf_active == 1'b0, "R12 pf_active", pf_active, 0);
    check(wr_ovf == 1'b0,    "R12 wr_ovf",    wr_ovf, 0);

    // hold keeps a burst from starting (R6)
    set_pci(1'b1, 1'b1);
    put_word(32'hA1B2_C3D4, 1'b1, 1'b1, 1'b1);
    put_word(32'h0000_FFFF, 1'b1, 1'b1, 1'b1);
    put_word(32'h1234_5678, 1'b1, 1'b1, 1'b1);
    repeat (10) @(posedge pclk);
    #3;
    check(empty_n == 1'b1,  "R5 not empty with data", empty_n, 1);
    check(rd_valid == 1'b0, "R6 no offer under hold", rd_valid, 0);
    check(pops == 0,        "R6 nothing taken under hold", pops, 0);
    set_pci(1'b0, 1'b1);
    wait_drain("R6 drain after hold release");

    // fill with hold high and no reader: almost full, full, drop, override (R3, R4, R7)
    repeat (10) @(posedge aclk);
    set_pci(1'b1, 1'b0);
    for (int k = 0; k < 11; k++) put_word(32'hC0DE_0000 + 32'(k), 1'b1, 1'b1, 1'b1);
    check(afull_n == 1'b1, "R4 five free", afull_n, 1);
    put_word(32'hC0DE_000B, 1'b1, 1'b1, 1'b1);
    check(afull_n == 1'b0, "R4 four free", afull_n, 0);
    check(full_n == 1'b1,  "R3 not yet full", full_n, 1);
    for (int k = 12; k < 16; k++) put_word(32'hC0DE_0000 + 32'(k), 1'b1, 1'b1, 1'b1);
    check(full_n == 1'b0, "R3 full at depth", full_n, 0);
    put_word(32'hDEAD_BEEF, 1'b1, 1'b1, 1'b0);
    repeat (2) @(posedge aclk);
    #3;
    check(ovf_cnt == 1, "R3 drop reported once", ovf_cnt, 1);
    repeat (8) @(posedge pclk);
    #3;
    check(rd_valid == 1'b1, "R7 full overrides hold", rd_valid, 1);
    check(rd_data == 32'hC0DE_0000, "R2 head held while stalled", rd_data, 32'hC0DE_0000);
    repeat (3) @(posedge pclk);
    #3;
    check(rd_data == 32'hC0DE_0000, "R2 head still held", rd_data, 32'hC0DE_0000);
    set_pci(1'b1, 1'b1);
    wait_drain("R7 burst runs to empty under hold");
    check(pops == 19, "R3 dropped word never delivered", pops, 19);
    repeat (10) @(posedge aclk);
    #3;
    check(full_n == 1'b1, "R3 full clears after drain", full_n, 1);

    // prefetch address stepping and end marker (R9, R10)
    set_pci(1'b0, 1'b1);
    start_pf(32'h0000_0120);
    check(pf_active == 1'b1 && pf_addr == 32'h120, "R9 start loads", pf_addr, 32'h120);
    put_word(32'h5555_0001, 1'b1, 1'b1, 1'b1);
    check(pf_addr == 32'h124, "R9 step of 4", pf_addr, 32'h124);
    put_word(32'h5555_0002, 1'b1, 1'b0, 1'b1);
    check(pf_addr == 32'h128, "R10 early marker ignored addr", pf_addr, 32'h128);
    check(pf_active == 1'b1,  "R10 early marker ignored active", pf_active, 1);
    put_word(32'h5555_0003, 1'b0, 1'b1, 1'b1);
    check(pf_active == 1'b0,  "R10 final marker stops", pf_active, 0);
    check(pf_addr == 32'h128, "R10 addr held at last word", pf_addr, 32'h128);
    put_word(32'h5555_0004, 1'b1, 1'b1, 1'b1);
    check(pf_addr == 32'h128, "R9 no step when inactive", pf_addr, 32'h128);

    // decode window limit (R11) and out-of-window start (R9)
    start_pf(32'h0000_01F8);
    put_word(32'h6666_0001, 1'b1, 1'b1, 1'b1);
    check(pf_addr == 32'h1FC && pf_active == 1'b1, "R11 reaches top", pf_addr, 32'h1FC);
    put_word(32'h6666_0002, 1'b1, 1'b1, 1'b1);
    check(pf_active == 1'b0,  "R11 stops at top", pf_active, 0);
    check(pf_addr == 32'h1FC, "R11 addr stays at top", pf_addr, 32'h1FC);
    start_pf(32'h0000_0200);
    check(pf_active == 1'b0, "R9 outside window rejected", pf_active, 0);
    wait_drain("R1 final drain");

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule